// File: doc/BRIEF.md
# Sliding-Window Pulse Rate Counter

This block measures the rate of a slow, asynchronous pulse signal against a fixed-frequency system clock. It counts rising edges of the pulse input. Once per second it publishes two figures: the count for the second that just closed, and the count over the most recent sixty seconds. A single-cycle strobe marks each update. The sixty-second figure is a true sliding window. A ring of per-second counts lets it advance by one second at every update, so it is never a counter that is cleared once a minute.

The pulse input passes through a synchronizer chain and then an edge detector. A clock divider marks each one-second boundary. A saturating live counter accumulates the edges of the current second. A small state machine publishes the results. It has two states. In ST_ACCUM the block counts and waits. Transition T_TICK happens at a second boundary: it latches the finished count and moves to ST_PUBLISH. In ST_PUBLISH the block reads the oldest ring slot and overwrites it with the new count. It adjusts the running sum, loads both outputs and raises the strobe. Transition T_DONE then returns it to ST_ACCUM after that one cycle. The one-second length is the parameter `TICKS_PER_SEC`, which defaults to 1000 clock cycles for a 1 kHz timebase. The window length and the counter width are also parameters.

Top module: `pulse_rate_counter`

## Requirements
- R1: While reset is high and in the cycle after it is released, `sec_count` and `min_count` are 0 and `update_stb` is 0. Reset also clears the divider, the live count, every ring slot and the running sum.
- R2: Each 0-to-1 transition of `pulse_in` counts once. A level held high for many cycles counts as one pulse, and a falling edge adds nothing.
- R3: At each update, `sec_count` equals the number of rising edges that fell inside the second that just ended.
- R4: At each update, `min_count` equals the sum of the per-second counts of the last `SLOTS` completed seconds (default 60). Before `SLOTS` seconds have completed since reset, it is the sum of the seconds completed so far.
- R5: `update_stb` is high for exactly one cycle every `TICKS_PER_SEC` cycles. `sec_count` and `min_count` change only in a cycle where `update_stb` is high.
- R6: An edge whose detection coincides with the second-boundary cycle counts toward the new second and not the one being closed. With a pulse input rising when the boundary is k clock edges away, the edge is counted in the new second for k = 3 and in the old second for k = 4.
- R7: The per-second count saturates at 2^CNT_W − 1 instead of wrapping.
- R8: `min_count` saturates at 2^CNT_W − 1 when the window sum exceeds it. It still follows the exact sum once the sum drops below that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock; `TICKS_PER_SEC` cycles make one second |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Asynchronous pulse signal to be counted |
| sec_count | output | CNT_W (16) | Rising edges in the last completed second |
| min_count | output | CNT_W (16) | Rising edges in the last `SLOTS` completed seconds |
| update_stb | output | 1 | High for the one cycle in which both counts take new values |

## Verification
The bench drives seconds that contain a varying number of short pulses. These show whether the live counter restarts at each boundary and whether the ring subtracts the right slot once more than sixty seconds have gone by. A single long high level, held across half a second, separates edge counting from level sampling. Two pulse placements one cycle apart around the second boundary pin the cycle in which an edge moves to the next second. A second instance with a 4-bit width receives more pulses than it can hold in one second. This shows that saturation clamps both outputs, and that the window sum stays exact underneath the clamped minute output.

// File: rtl/prc_pkg.sv
package prc_pkg;

    // Publish sequencer states
    typedef enum logic [0:0] {
        ST_ACCUM   = 1'b0,
        ST_PUBLISH = 1'b1
    } prc_state_e;

endpackage

// File: rtl/prc_sync_edge.sv
// Synchronizer chain followed by a rising-edge detector.
module prc_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    output logic rise
);
    // chain_q[SYNC_STAGES-1] is the synchronized level; chain_q[SYNC_STAGES] is its previous sample
    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], pulse_in};
        end
    end

    assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/prc_tick.sv
// One-second divider: asserts tick once every TICKS_PER_SEC cycles.
module prc_tick #(
    parameter int TICKS_PER_SEC = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DIV_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICKS_PER_SEC - 1);

    logic [DIV_W-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/prc_live_count.sv
// Saturating count of edges in the current second.
module prc_live_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             tick,
    output logic [CNT_W-1:0] done_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    // Value handed over at the boundary excludes an edge in that same cycle
    assign done_count = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= rise ? CNT_W'(1) : '0;
        end else if (rise && (count_q != CNT_MAX)) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/prc_window.sv
// Ring of per-second counts, running sum and publish sequencer.
module prc_window
    import prc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SLOTS = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] sec_in,
    output logic [CNT_W-1:0] sec_count,
    output logic [CNT_W-1:0] min_count,
    output logic             update_stb
);
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int SUM_W = CNT_W + $clog2(SLOTS + 1);
    localparam logic [SUM_W-1:0] SUM_SAT  = SUM_W'({CNT_W{1'b1}});
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(SLOTS - 1);

    prc_state_e state_q, state_d;

    logic [CNT_W-1:0] ring_q [SLOTS];
    logic [PTR_W-1:0] wptr_q;
    logic [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] old_val;
    logic [SUM_W-1:0] sum_next;
    logic [CNT_W-1:0] min_next;

    assign old_val  = ring_q[wptr_q];
    assign sum_next = sum_q + SUM_W'(hold_q) - SUM_W'(old_val);
    assign min_next = (sum_next > SUM_SAT) ? {CNT_W{1'b1}} : sum_next[CNT_W-1:0];

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACCUM;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_TICK (ST_ACCUM -> ST_PUBLISH), T_DONE (ST_PUBLISH -> ST_ACCUM)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCUM:   if (tick) state_d = ST_PUBLISH;
            ST_PUBLISH: state_d = ST_ACCUM;
            default:    state_d = ST_ACCUM;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                ring_q[i] <= '0;
            end
            wptr_q     <= '0;
            sum_q      <= '0;
            hold_q     <= '0;
            sec_count  <= '0;
            min_count  <= '0;
            update_stb <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ACCUM: begin
                    update_stb <= 1'b0;
                    if (tick) begin
                        hold_q <= sec_in;
                    end
                end
                ST_PUBLISH: begin
                    ring_q[wptr_q] <= hold_q;
                    wptr_q         <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
                    sum_q          <= sum_next;
                    sec_count      <= hold_q;
                    min_count      <= min_next;
                    update_stb     <= 1'b1;
                end
                default: update_stb <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pulse_rate_counter.sv
// Top: pulse rate over the last second and over a sliding window of seconds.
module pulse_rate_counter #(
    parameter int CNT_W         = 16,
    parameter int TICKS_PER_SEC = 1000,
    parameter int SLOTS         = 60,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_in,
    output logic [CNT_W-1:0] sec_count,
    output logic [CNT_W-1:0] min_count,
    output logic             update_stb
);
    logic             rise;
    logic             tick;
    logic [CNT_W-1:0] done_count;

    prc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (pulse_in),
        .rise     (rise)
    );

    prc_tick #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    prc_live_count #(.CNT_W(CNT_W)) u_live (
        .clk        (clk),
        .rst        (rst),
        .rise       (rise),
        .tick       (tick),
        .done_count (done_count)
    );

    prc_window #(.CNT_W(CNT_W), .SLOTS(SLOTS)) u_window (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .sec_in     (done_count),
        .sec_count  (sec_count),
        .min_count  (min_count),
        .update_stb (update_stb)
    );

endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
    parameter int CNT_W         = 16,
    parameter int TICKS_PER_SEC = 1000
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] sec_count,
    input logic [CNT_W-1:0] min_count,
    input logic             update_stb
);
    localparam int GAP_W = $clog2(TICKS_PER_SEC) + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (update_stb) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (sec_count == '0) && (min_count == '0) && !update_stb);

    // R5
    p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
        !update_stb |-> ($stable(sec_count) && $stable(min_count)));

    // R5
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
        update_stb |=> !update_stb);

    // R5
    p_strobe_period_r5: assert property (@(posedge clk) disable iff (rst)
        (update_stb && seen_q) |-> (gap_q == GAP_W'(TICKS_PER_SEC - 1)));

    // R4
    p_window_covers_second_r4: assert property (@(posedge clk) disable iff (rst)
        min_count >= sec_count);

endmodule

bind pulse_rate_counter prc_checker #(
    .CNT_W         (CNT_W),
    .TICKS_PER_SEC (TICKS_PER_SEC)
) u_prc_checker (
    .clk        (clk),
    .rst        (rst),
    .sec_count  (sec_count),
    .min_count  (min_count),
    .update_stb (update_stb)
);

// File: tb/test_pulse_rate_counter.sv
module test_pulse_rate_counter;
    localparam int T = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pulse_in = 1'b0;
    logic        pulse_sat = 1'b0;
    logic [15:0] sec_count, min_count;
    logic        update_stb;
    logic [3:0]  sec_sat, min_sat;
    logic        stb_sat;

    int hist [0:199];
    int nh = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pulse_rate_counter #(.CNT_W(16), .TICKS_PER_SEC(T), .SLOTS(60)) i_pulse_rate_counter (
        .clk(clk), .rst(rst), .pulse_in(pulse_in),
        .sec_count(sec_count), .min_count(min_count), .update_stb(update_stb)
    );

    pulse_rate_counter #(.CNT_W(4), .TICKS_PER_SEC(T), .SLOTS(60)) i_pulse_rate_counter_sat (
        .clk(clk), .rst(rst), .pulse_in(pulse_sat),
        .sec_count(sec_sat), .min_count(min_sat), .update_stb(stb_sat)
    );

    task automatic chk_eq(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int exp_min();
        int s = 0;
        for (int i = 0; i < 60 && i < nh; i++) s += hist[nh-1-i];
        if (s > 65535) s = 65535;
        return s;
    endfunction

    task automatic check_second(input int n, input string tag);
        hist[nh] = n;
        nh++;
        chk_eq({tag, " R3 sec_count"}, int'(sec_count), n);
        chk_eq({tag, " R4 min_count"}, int'(min_count), exp_min());
    endtask

    // One second of n short pulses; starts and ends on the negedge after a strobe
    task automatic t_second(input int n, input string tag);
        int k = 0;
        int s0 = int'(sec_count);
        int m0 = int'(min_count);
        forever begin
            @(negedge clk);
            k++;
            if (update_stb) break;
            if (k == T / 2) begin
                chk_eq({tag, " R5 sec held"}, int'(sec_count), s0);
                chk_eq({tag, " R5 min held"}, int'(min_count), m0);
            end
            pulse_in = (k <= 4 * n) && (((k - 1) % 4) < 2);
        end
        pulse_in = 1'b0;
        chk_eq({tag, " R5 strobe period"}, k, T);
        check_second(n, tag);
    endtask

    // R2: one long level counts once
    task automatic t_level();
        int k = 0;
        forever begin
            @(negedge clk);
            k++;
            if (update_stb) break;
            pulse_in = (k >= 2) && (k <= 40);
        end
        pulse_in = 1'b0;
        check_second(1, "R2 level");
    endtask

    // R6: rise kb negedges after a strobe, near the next boundary
    task automatic t_boundary(input bit late);
        int kb = late ? T - 4 : T - 5;
        int e1 = late ? 2 : 3;
        int e2 = late ? 1 : 0;
        for (int k = 1; k <= 2 * T; k++) begin
            @(negedge clk);
            if (k == T || k == 2 * T) begin
                chk_eq("R6 strobe at boundary", int'(update_stb), 1);
                check_second((k == T) ? e1 : e2, late ? "R6 late" : "R6 early");
            end
            pulse_in = ((k >= 2) && (k <= 3)) || ((k >= 6) && (k <= 7)) ||
                       ((k >= kb) && (k < kb + 6));
        end
        pulse_in = 1'b0;
    endtask

    // R7/R8 on the 4-bit instance
    task automatic t_saturate();
        for (int s = 0; s < 2; s++) begin
            int k = 0;
            int np = (s == 0) ? 20 : 5;
            forever begin
                @(negedge clk);
                k++;
                if (update_stb) break;
                pulse_sat = (k <= 2 * np) && (k % 2 == 1);
            end
            pulse_sat = 1'b0;
            chk_eq("R7 sat strobe aligned", int'(stb_sat), 1);
            chk_eq("R7 sec saturated", int'(sec_sat), (s == 0) ? 15 : 5);
            chk_eq("R8 min saturated", int'(min_sat), 15);
            check_second(0, "R7 idle main");
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk_eq("R1 sec in reset", int'(sec_count), 0);
        chk_eq("R1 strobe in reset", int'(update_stb), 0);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 sec after reset", int'(sec_count), 0);
        chk_eq("R1 min after reset", int'(min_count), 0);
        chk_eq("R1 strobe after reset", int'(update_stb), 0);
        chk_eq("R1 sat min after reset", int'(min_sat), 0);
        while (!update_stb) @(negedge clk);
        check_second(0, "R1 first second");
        t_second(3, "R3 three");
        t_second(0, "R3 empty");
        t_second(12, "R3 dense");
        t_level();
        t_boundary(1'b1);
        t_boundary(1'b0);
        t_saturate();
        for (int i = 0; i < 62; i++) t_second((i * 7) % 13, "R4 slide");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule